// File: doc/BRIEF.md
# Extreme-Value Search Unit

This block keeps a running maximum or minimum over a stream of 24-bit signed operands. It also records where the current extreme was found. The operands are read through an address pointer that the block owns. Each search step takes two cycles. The compare cycle tests the operand against the held extreme and sets a negative flag when the operand is a new extreme. The load cycle then takes that operand as the new extreme, if the flag says so, and writes the pointer value into the index register. The pointer value used is the one from before the load cycle moves it.

In a typical loop the compare cycle moves the pointer by zero and the load cycle moves it by the search stride. Both cycles therefore present the same element on `operand_i`. A synchronous clear starts a new search and picks maximum or minimum mode. Instruction decode and operand memory sit outside the block.

Top module: `extreme_search`

## Requirements
- R1: A step begins when `step_i` is high in an idle cycle, and it ends one cycle later. That next cycle is the load cycle. `step_i` is ignored during the load cycle. A new step can begin in the cycle after the load cycle.
- R2: In maximum mode (`mode_min_i`=0 at clear), the extreme register `extreme_o` ends each step holding the largest signed value seen so far.
- R3: In minimum mode (`mode_min_i`=1 at clear), `extreme_o` ends each step holding the smallest signed value seen so far.
- R4: If the operand equals the held extreme, `n_o` goes to 0 and neither `extreme_o` nor `index_o` changes.
- R5: `n_o` is updated at the end of every compare cycle. It is 1 exactly when the operand is strictly greater than the held extreme (maximum mode) or strictly less than it (minimum mode). The comparison is correct over the full 24-bit signed range.
- R6: `addr_o` advances by the signed 8-bit `cmp_mod_i` at the end of the compare cycle. It advances by the signed 8-bit `stride_i` at the end of the load cycle. It wraps modulo 2^16 and otherwise holds its value.
- R7: When a new extreme is taken, `index_o[14:0]` gets `addr_o[14:0]` as it stood during the load cycle, before that cycle moves it. `index_o[15]` keeps its value.
- R8: `clr_i` sets `extreme_o` to 0x800000 in maximum mode or to 0x7FFFFF in minimum mode. It also clears `index_o` and `n_o`, stores the mode, and ends any step in progress. Clear takes priority over `step_i`.
- R9: After reset the block is in maximum mode with `extreme_o`=0x800000 and `index_o`, `n_o` and `addr_o` all zero.
- R10: `ptr_load_i` writes `ptr_value_i` into `addr_o` on the next edge, and it takes priority over any pointer movement in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Start a new search; picks the mode |
| mode_min_i | input | 1 | Mode sampled at clear: 0 maximum, 1 minimum |
| step_i | input | 1 | Begin a compare/load step |
| operand_i | input | 24 | Signed operand at the current address |
| ptr_load_i | input | 1 | Load the address pointer |
| ptr_value_i | input | 16 | Value for the pointer load |
| cmp_mod_i | input | 8 | Signed pointer change after the compare cycle |
| stride_i | input | 8 | Signed pointer change after the load cycle |
| addr_o | output | 16 | Current address pointer |
| extreme_o | output | 24 | Held extreme value |
| index_o | output | 16 | Index register; low 15 bits latch the address |
| n_o | output | 1 | Negative flag from the last compare |

## Verification
The assertions run on every cycle and check four things:
- a load cycle is always followed by an idle cycle;
- the held extreme never moves the wrong way for the stored mode;
- the extreme changes only on a flagged load or a clear;
- the pointer does not move when no step or pointer load is active.

Some behaviours need the bench's scenarios, because they depend on the operand values:
- the exact N flag at the signed range limits;
- the equal-operand case;
- the address captured in the index, including the dropped bit 15;
- the effect of a nonzero compare-cycle modifier;
- clear winning over a simultaneous step.

// File: rtl/ext_pkg.sv
package ext_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_LOAD = 1'b1
  } phase_e;
endpackage

// File: rtl/ext_ctrl.sv
module ext_ctrl
  import ext_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic step_i,
  output logic cmp_en_o,
  output logic load_en_o
);
  phase_e phase_q;

  assign cmp_en_o  = step_i && (phase_q == PH_IDLE) && !clr_i;
  assign load_en_o = (phase_q == PH_LOAD) && !clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  phase_q <= PH_IDLE;
    else if (cmp_en_o) phase_q <= PH_LOAD;
    else               phase_q <= PH_IDLE;
  end

  // R1: a load cycle is always followed by an idle cycle
  assert_load_then_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LOAD) |=> (phase_q == PH_IDLE));

  // R1: a step may not begin during the load cycle
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
    !(cmp_en_o && load_en_o));
endmodule

// File: rtl/ext_cmp.sv
module ext_cmp #(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] extreme_i,
  input  logic              min_mode_i,
  output logic              take_o
);
  localparam int EXT_W = DATA_W + 1;

  logic signed [EXT_W-1:0] op_x;
  logic signed [EXT_W-1:0] ex_x;
  logic signed [EXT_W-1:0] diff;

  always_comb begin
    op_x = {operand_i[DATA_W-1], operand_i};
    ex_x = {extreme_i[DATA_W-1], extreme_i};
    // a negative difference marks a strictly better operand
    if (min_mode_i) diff = op_x - ex_x;
    else            diff = ex_x - op_x;
    take_o = diff[EXT_W-1];
  end
endmodule

// File: rtl/ext_agu.sv
module ext_agu #(
  parameter int PTR_W = 16,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_val_i,
  input  logic             cmp_en_i,
  input  logic             load_en_i,
  input  logic [MOD_W-1:0] cmp_mod_i,
  input  logic [MOD_W-1:0] stride_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int PAD_W = PTR_W - MOD_W;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] delta;

  always_comb begin
    if (load_en_i) delta = {{PAD_W{stride_i[MOD_W-1]}}, stride_i};
    else           delta = {{PAD_W{cmp_mod_i[MOD_W-1]}}, cmp_mod_i};
  end

  always_ff @(posedge clk) begin
    if (rst)                         ptr_q <= '0;
    else if (ld_i)                   ptr_q <= ld_val_i;
    else if (cmp_en_i || load_en_i)  ptr_q <= ptr_q + delta;
  end

  assign ptr_o = ptr_q;

  // R6: no movement without a step or a load
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !cmp_en_i && !load_en_i) |=> $stable(ptr_q));

  // R10: a pointer load lands on the next edge
  assert_ptr_load_R10: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (ptr_q == $past(ld_val_i)));
endmodule

// File: rtl/extreme_search.sv
module extreme_search #(
  parameter int DATA_W  = 24,
  parameter int PTR_W   = 16,
  parameter int MOD_W   = 8,
  parameter int IDX_W   = 16,
  parameter int LATCH_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              mode_min_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              ptr_load_i,
  input  logic [PTR_W-1:0]  ptr_value_i,
  input  logic [MOD_W-1:0]  cmp_mod_i,
  input  logic [MOD_W-1:0]  stride_i,
  output logic [PTR_W-1:0]  addr_o,
  output logic [DATA_W-1:0] extreme_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              n_o
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic              cmp_en;
  logic              load_en;
  logic              take;
  logic              mode_q;
  logic              n_q;
  logic [DATA_W-1:0] ext_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PTR_W-1:0]  ptr;

  ext_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_i),
    .step_i    (step_i),
    .cmp_en_o  (cmp_en),
    .load_en_o (load_en)
  );

  ext_cmp #(.DATA_W(DATA_W)) u_cmp (
    .operand_i  (operand_i),
    .extreme_i  (ext_q),
    .min_mode_i (mode_q),
    .take_o     (take)
  );

  ext_agu #(.PTR_W(PTR_W), .MOD_W(MOD_W)) u_agu (
    .clk       (clk),
    .rst       (rst),
    .ld_i      (ptr_load_i),
    .ld_val_i  (ptr_value_i),
    .cmp_en_i  (cmp_en),
    .load_en_i (load_en),
    .cmp_mod_i (cmp_mod_i),
    .stride_i  (stride_i),
    .ptr_o     (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      ext_q  <= MOST_NEG;
      idx_q  <= '0;
      n_q    <= 1'b0;
    end else if (clr_i) begin
      mode_q <= mode_min_i;
      ext_q  <= mode_min_i ? MOST_POS : MOST_NEG;
      idx_q  <= '0;
      n_q    <= 1'b0;
    end else begin
      if (cmp_en) n_q <= take;
      if (load_en && n_q) begin
        ext_q              <= operand_i;
        idx_q[LATCH_W-1:0] <= ptr[LATCH_W-1:0];
      end
    end
  end

  assign addr_o    = ptr;
  assign extreme_o = ext_q;
  assign index_o   = idx_q;
  assign n_o       = n_q;

  // R1: the extreme moves only on a flagged load or a clear
  assert_ext_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !(load_en && n_q)) |=> $stable(ext_q));

  // R2: in maximum mode the extreme never decreases
  assert_max_monotone_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !mode_q) |=> ($signed(ext_q) >= $signed($past(ext_q))));

  // R3: in minimum mode the extreme never increases
  assert_min_monotone_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && mode_q) |=> ($signed(ext_q) <= $signed($past(ext_q))));

  // R7: bits above the latched field are kept
  assert_idx_upper_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> $stable(idx_q[IDX_W-1:LATCH_W]));
endmodule

// File: tb/extreme_search_tb.sv
module extreme_search_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        clr_i, mode_min_i, step_i, ptr_load_i;
  logic [23:0] operand_i;
  logic [15:0] ptr_value_i;
  logic [7:0]  cmp_mod_i, stride_i;
  logic [15:0] addr_o;
  logic [23:0] extreme_o;
  logic [15:0] index_o;
  logic        n_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  extreme_search dut_i (
    .clk(clk), .rst(rst), .clr_i(clr_i), .mode_min_i(mode_min_i),
    .step_i(step_i), .operand_i(operand_i), .ptr_load_i(ptr_load_i),
    .ptr_value_i(ptr_value_i), .cmp_mod_i(cmp_mod_i), .stride_i(stride_i),
    .addr_o(addr_o), .extreme_o(extreme_o), .index_o(index_o), .n_o(n_o)
  );

  typedef struct packed {
    logic [23:0] op;
    logic [23:0] ext;
    logic [15:0] idx;
    logic        n;
  } vec_t;

  // maximum mode, pointer from 0x0100, compare modifier 0, stride 3
  localparam vec_t VECS [5] = '{
    '{24'h000005, 24'h000005, 16'h0100, 1'b1},  // R2 R5 new max
    '{24'hFFFFFD, 24'h000005, 16'h0100, 1'b0},  // R2 smaller ignored
    '{24'h000005, 24'h000005, 16'h0100, 1'b0},  // R4 equal
    '{24'h7FFFFF, 24'h7FFFFF, 16'h0109, 1'b1},  // R5 top of range
    '{24'h800000, 24'h7FFFFF, 16'h0109, 1'b0}   // R5 no overflow
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_step(logic [23:0] op);
    @(negedge clk); step_i = 1'b1; operand_i = op;
    @(negedge clk); step_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear(logic mn);
    @(negedge clk); clr_i = 1'b1; mode_min_i = mn;
    @(negedge clk); clr_i = 1'b0;
  endtask

  task automatic load_ptr(logic [15:0] v);
    @(negedge clk); ptr_load_i = 1'b1; ptr_value_i = v;
    @(negedge clk); ptr_load_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; clr_i = 1'b0; mode_min_i = 1'b0; step_i = 1'b0;
    ptr_load_i = 1'b0; operand_i = '0; ptr_value_i = '0;
    cmp_mod_i = 8'h00; stride_i = 8'h03;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 extreme", {8'h0, extreme_o}, 32'h00800000);
    check("R9 index", {16'h0, index_o}, 32'h0);
    check("R9 n", {31'h0, n_o}, 32'h0);
    check("R9 addr", {16'h0, addr_o}, 32'h0);

    do_clear(1'b0);
    load_ptr(16'h0100);
    check("R10 addr", {16'h0, addr_o}, 32'h0100);
    for (int i = 0; i < 5; i++) begin
      do_step(VECS[i].op);
      check("R2 extreme", {8'h0, extreme_o}, {8'h0, VECS[i].ext});
      check("R7 index", {16'h0, index_o}, {16'h0, VECS[i].idx});
      check("R5 n", {31'h0, n_o}, {31'h0, VECS[i].n});
      check("R6 addr", {16'h0, addr_o}, 32'h0100 + 32'(3 * (i + 1)));
    end

    // R8 minimum mode clear
    do_clear(1'b1);
    check("R8 extreme min", {8'h0, extreme_o}, 32'h007FFFFF);
    check("R8 index", {16'h0, index_o}, 32'h0);
    check("R8 n", {31'h0, n_o}, 32'h0);

    // R3 R7: bit 15 of the address is not latched, negative stride
    stride_i = 8'hFF;
    load_ptr(16'h8005);
    do_step(24'h00000A);
    check("R3 extreme", {8'h0, extreme_o}, 32'h0000000A);
    check("R7 index low field", {16'h0, index_o}, 32'h0005);
    check("R6 negative stride", {16'h0, addr_o}, 32'h8004);
    do_step(24'h800000);
    check("R3 extreme bottom", {8'h0, extreme_o}, 32'h00800000);
    check("R7 index", {16'h0, index_o}, 32'h0004);
    do_step(24'h7FFFFF);
    check("R5 n min", {31'h0, n_o}, 32'h0);
    check("R3 extreme held", {8'h0, extreme_o}, 32'h00800000);

    // R6 R7: compare modifier moves the pointer before the latch
    do_clear(1'b0);
    cmp_mod_i = 8'h01; stride_i = 8'h02;
    load_ptr(16'h0020);
    do_step(24'h000010);
    check("R7 post-compare address", {16'h0, index_o}, 32'h0021);
    check("R6 both modifiers", {16'h0, addr_o}, 32'h0023);

    // R1: step held across the load cycle starts only one step
    cmp_mod_i = 8'h00; stride_i = 8'h04;
    load_ptr(16'h0040);
    @(negedge clk); step_i = 1'b1; operand_i = 24'h000020;
    @(negedge clk);
    check("R1 compare only", {16'h0, addr_o}, 32'h0040);
    @(negedge clk); step_i = 1'b0;
    check("R1 single step", {16'h0, addr_o}, 32'h0044);
    check("R1 extreme", {8'h0, extreme_o}, 32'h00000020);
    check("R1 index", {16'h0, index_o}, 32'h0040);

    // R8: clear wins over a simultaneous step
    @(negedge clk); clr_i = 1'b1; mode_min_i = 1'b1; step_i = 1'b1;
    operand_i = 24'h000001;
    @(negedge clk); clr_i = 1'b0; step_i = 1'b0;
    @(negedge clk);
    check("R8 clear priority extreme", {8'h0, extreme_o}, 32'h007FFFFF);
    check("R8 clear priority addr", {16'h0, addr_o}, 32'h0044);
    check("R8 clear priority n", {31'h0, n_o}, 32'h0);

    finish_run();
  end
endmodule